// File: doc/BRIEF.md
# PRBS Test Pattern Generator

A serial source of pseudo-random test data for bit-error-ratio work. Each clock it emits one bit of a maximal-length PRBS, chosen from seven register lengths, along with the bit's complement and a trigger pulse. For the four short lengths, the stream can be shaped in two ways. Three consecutive sequence bits can be combined to set the density of ones anywhere from 1/8 to 7/8. A programmable run of zeros can also be forced after a single marker one at the start of each pattern period.

Errors are placed on purpose by inverting one output bit. Three sources can do this: a software-style single-error command, an active-low external inject pin, and a decade-rate engine. The decade-rate engine flips one bit in every 10^n valid bits, for n from 3 to 9. A small state machine runs the rate engine. It has two states, `EI_IDLE` and `EI_COUNT`. It moves from idle to counting when the rate enable is seen high, and back to idle when the enable is seen low. In `EI_COUNT` its terminal count fires a flip and restarts the count.

The trigger output gives one of three pulses: once per pattern period, once every 32 clocks, or once every 8 clocks. The data enable parks the data pair at a static level.

Top module: `prbs_tpg`

## Requirements
- R1: While `rst` is high, at every clock edge, `data_o` is 0, `data_no` is 1 and `trig_o` is 0. Reset seeds the shift register to all ones, clears the bit position, the divider and the error counter, and latches `pat_sel`.
- R2: `pat_sel` selects the sequence as follows: 0 gives 7 bits with taps 7,6; 1 gives 10 bits with taps 10,7; 2 gives 11 bits with taps 11,9; 3 gives 13 bits with taps 13,12,2,1; 4 gives 15 bits with taps 15,14; 5 gives 23 bits with taps 23,18; 6 and 7 give 31 bits with taps 31,28. The register shifts toward its top bit. Its new bit 1 (counting from 1) is the XOR of the tap bits. The stream bit is the top bit of the register. Stream bit k appears on `data_o` after the (k+1)th rising edge following reset release, and the register never holds all zeros.
- R3: The bit position counts 0 to 2^n-2 and then wraps. With `trig_mode` 0 or 3, `trig_o` is high exactly on the bit at position 0.
- R4: `data_no` is always the inverse of `data_o`. While `data_oe` is low, `data_o` is 0 and `data_no` is 1 on the next clock.
- R5: With `zsub_en` high on lengths 7, 10, 11 or 13 bits, the bit at position 0 is 1. Positions 1..K are 0, where K is `zsub_len` limited to 2^n-2. Zero substitution overrides density shaping.
- R6: On the 15, 23 and 31 bit lengths, `zsub_en` and `dens_code` have no effect on the output.
- R7: On the short lengths, with a the current stream bit, b the previous one and c the one before that (b and c read 0 after reset or reseed), `dens_code` gives: 1: a&b&c; 2: a&b; 3: a&(b|c); 4 or 0: a; 5: a|(b&c); 6: a|b; 7: a|b|c.
- R8: A rising edge of `err_single` flips exactly one output bit, the one captured at that edge. Holding the input high flips nothing more.
- R9: A falling edge of `err_ext_n` flips exactly one output bit, the one captured at that edge.
- R10: When `rate_en` is high, counting starts on the clock after enable is seen. The engine flips the valid bit on which its count reaches 10^n and then restarts. n is `rate_exp` clamped to 3..9.
- R11: `trig_mode` 1 pulses `trig_o` once every 32 clocks and `trig_mode` 2 once every 8 clocks. Both pulse on the first clock after reset.
- R12: A change of `pat_sel` lets the current bit finish. The next bit is position 0 of the new sequence, starting from the all-ones seed.
- R13: While `data_oe` is low, error events are discarded and the rate counter does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pat_sel | input | 3 | Sequence length select |
| trig_mode | input | 2 | Trigger source select |
| dens_code | input | 3 | Ones-density code, eighths |
| zsub_en | input | 1 | Zero-run substitution enable |
| zsub_len | input | 13 | Forced zero-run length |
| err_single | input | 1 | Single error command, rising edge |
| err_ext_n | input | 1 | External error inject, falling edge |
| rate_en | input | 1 | Decade-rate error enable |
| rate_exp | input | 4 | Decade exponent n |
| data_oe | input | 1 | Data output enable |
| data_o | output | 1 | Data bit |
| data_no | output | 1 | Inverted data bit |
| trig_o | output | 1 | Trigger pulse |

## Verification
The assertions assume that every control input is synchronous to `clk`. The error inputs are edge-detected with no synchronizer, so they must not change near an edge. The zero-marker check also assumes that no error event coincides with position 0 while substitution is active. The bench changes all inputs only at falling edges. It places single and external error pulses on the 7-bit sequence with substitution off. It enables the rate engine only at exponents whose spacing (at least 1000 bits) keeps consecutive rate flips apart.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int LFSR_W = 31;
    localparam int CNT_W  = 30;
    localparam int ZLEN_W = 13;
    localparam int DIV_W  = 5;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        PAT_7, PAT_10, PAT_11, PAT_13, PAT_15, PAT_23, PAT_31, PAT_31X
    } pat_e;

    typedef enum logic [1:0] {
        TRG_PATTERN, TRG_DIV32, TRG_DIV8, TRG_PATTERN_ALT
    } trig_e;

    typedef enum logic {
        EI_IDLE, EI_COUNT
    } ei_state_e;

    function automatic int unsigned pat_order(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 7;
            3'd1:    return 10;
            3'd2:    return 11;
            3'd3:    return 13;
            3'd4:    return 15;
            3'd5:    return 23;
            default: return 31;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] pat_mask(input logic [SEL_W-1:0] sel);
        logic [LFSR_W:0] m;
        m = ((LFSR_W+1)'(1) << pat_order(sel)) - (LFSR_W+1)'(1);
        return m[LFSR_W-1:0];
    endfunction

    function automatic logic is_short(input logic [SEL_W-1:0] sel);
        return sel <= 3'd3;
    endfunction

    function automatic logic [CNT_W-1:0] decade_limit(input logic [3:0] e);
        logic [3:0]       k;
        logic [CNT_W-1:0] v;
        k = (e < 4'd3) ? 4'd3 : ((e > 4'd9) ? 4'd9 : e);
        v = CNT_W'(1);
        for (int i = 0; i < 9; i++) begin
            if (i < int'(k)) v = v * CNT_W'(10);
        end
        return v;
    endfunction

endpackage

// File: rtl/prbs_lfsr.sv
module prbs_lfsr
    import prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [SEL_W-1:0]  sel_q,
    output logic              raw_o,
    output logic              hist1_o,
    output logic              hist2_o,
    output logic [LFSR_W-1:0] pos_o
);

    logic [LFSR_W-1:0] shreg, shreg_nx, mask, last;
    logic              fb;
    logic [4:0]        msb;
    pat_e              cur;

    always_comb begin
        cur  = pat_e'(sel_q);
        mask = pat_mask(sel_q);
        last = mask - LFSR_W'(1);
        msb  = 5'(pat_order(sel_q) - 1);
        unique case (cur)
            PAT_7:            fb = shreg[6]  ^ shreg[5];
            PAT_10:           fb = shreg[9]  ^ shreg[6];
            PAT_11:           fb = shreg[10] ^ shreg[8];
            PAT_13:           fb = shreg[12] ^ shreg[11] ^ shreg[1] ^ shreg[0];
            PAT_15:           fb = shreg[14] ^ shreg[13];
            PAT_23:           fb = shreg[22] ^ shreg[17];
            PAT_31, PAT_31X:  fb = shreg[30] ^ shreg[27];
        endcase
        shreg_nx = {shreg[LFSR_W-2:0], fb};
        if ((shreg_nx & mask) == '0) shreg_nx = '1;
    end

    assign raw_o = shreg[msb];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '1;
            sel_q   <= sel_in;
            hist1_o <= 1'b0;
            hist2_o <= 1'b0;
            pos_o   <= '0;
        end else if (sel_in != sel_q) begin
            shreg   <= '1;
            sel_q   <= sel_in;
            hist1_o <= 1'b0;
            hist2_o <= 1'b0;
            pos_o   <= '0;
        end else begin
            shreg   <= shreg_nx;
            hist1_o <= raw_o;
            hist2_o <= hist1_o;
            pos_o   <= (pos_o == last) ? '0 : pos_o + LFSR_W'(1);
        end
    end

    assert_no_lockup_R2: assert property (@(posedge clk) disable iff (rst)
        (shreg & mask) != '0);

    assert_reseed_R12: assert property (@(posedge clk) disable iff (rst)
        (sel_in != sel_q) |=> (pos_o == '0 && shreg == '1));

    assert_pos_range_R3: assert property (@(posedge clk) disable iff (rst)
        pos_o <= last);

endmodule

// File: rtl/prbs_shaper.sv
module prbs_shaper
    import prbs_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_q,
    input  logic              raw_i,
    input  logic              hist1_i,
    input  logic              hist2_i,
    input  logic [LFSR_W-1:0] pos_i,
    input  logic [2:0]        dens_code,
    input  logic              zsub_en,
    input  logic [ZLEN_W-1:0] zsub_len,
    output logic              bit_o
);

    logic              short_p, dens_bit;
    logic [LFSR_W-1:0] run_lim, run_req;

    always_comb begin
        short_p = is_short(sel_q);
        unique case (dens_code)
            3'd1:    dens_bit = raw_i & hist1_i & hist2_i;
            3'd2:    dens_bit = raw_i & hist1_i;
            3'd3:    dens_bit = raw_i & (hist1_i | hist2_i);
            3'd5:    dens_bit = raw_i | (hist1_i & hist2_i);
            3'd6:    dens_bit = raw_i | hist1_i;
            3'd7:    dens_bit = raw_i | hist1_i | hist2_i;
            default: dens_bit = raw_i;
        endcase
        run_lim = pat_mask(sel_q) - LFSR_W'(1);
        run_req = LFSR_W'(zsub_len);
        if (run_req > run_lim) run_req = run_lim;
        bit_o = short_p ? dens_bit : raw_i;
        if (short_p && zsub_en) begin
            if (pos_i == '0)           bit_o = 1'b1;
            else if (pos_i <= run_req) bit_o = 1'b0;
        end
    end

endmodule

// File: rtl/prbs_err.sv
module prbs_err
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       data_oe,
    input  logic       err_single,
    input  logic       err_ext_n,
    input  logic       rate_en,
    input  logic [3:0] rate_exp,
    output logic       flip_o
);

    ei_state_e        st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx, lim;
    logic             single_q, ext_q, single_ev, ext_ev, rate_hit;

    always_ff @(posedge clk) begin
        if (rst) st <= EI_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        lim       = decade_limit(rate_exp);
        single_ev = err_single & ~single_q;
        ext_ev    = ~err_ext_n & ext_q;
        rate_hit  = 1'b0;
        st_nx     = st;
        cnt_nx    = cnt;
        unique case (st)
            EI_IDLE: begin
                cnt_nx = '0;
                if (rate_en) st_nx = EI_COUNT;
            end
            EI_COUNT: begin
                if (!rate_en) begin
                    st_nx  = EI_IDLE;
                    cnt_nx = '0;
                end else if (data_oe) begin
                    rate_hit = (cnt >= lim - CNT_W'(1));
                    cnt_nx   = rate_hit ? '0 : cnt + CNT_W'(1);
                end
            end
        endcase
        flip_o = data_oe & (single_ev | ext_ev | rate_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            single_q <= 1'b0;
            ext_q    <= 1'b1;
        end else begin
            cnt      <= cnt_nx;
            single_q <= err_single;
            ext_q    <= err_ext_n;
        end
    end

    assert_rate_gap_R10: assert property (@(posedge clk) disable iff (rst)
        rate_hit |=> !rate_hit);

endmodule

// File: rtl/prbs_tpg.sv
module prbs_tpg
    import prbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  pat_sel,
    input  logic [1:0]  trig_mode,
    input  logic [2:0]  dens_code,
    input  logic        zsub_en,
    input  logic [12:0] zsub_len,
    input  logic        err_single,
    input  logic        err_ext_n,
    input  logic        rate_en,
    input  logic [3:0]  rate_exp,
    input  logic        data_oe,
    output logic        data_o,
    output logic        data_no,
    output logic        trig_o
);

    logic [SEL_W-1:0]  sel_q;
    logic              raw, h1, h2, shaped, flip, bit_nx, trig_nx;
    logic [LFSR_W-1:0] pos;
    logic [DIV_W-1:0]  div;
    trig_e             tmode;

    prbs_lfsr u_lfsr (
        .clk(clk), .rst(rst), .sel_in(pat_sel), .sel_q(sel_q),
        .raw_o(raw), .hist1_o(h1), .hist2_o(h2), .pos_o(pos)
    );

    prbs_shaper u_shaper (
        .sel_q(sel_q), .raw_i(raw), .hist1_i(h1), .hist2_i(h2), .pos_i(pos),
        .dens_code(dens_code), .zsub_en(zsub_en), .zsub_len(zsub_len),
        .bit_o(shaped)
    );

    prbs_err u_err (
        .clk(clk), .rst(rst), .data_oe(data_oe), .err_single(err_single),
        .err_ext_n(err_ext_n), .rate_en(rate_en), .rate_exp(rate_exp),
        .flip_o(flip)
    );

    always_comb begin
        tmode  = trig_e'(trig_mode);
        bit_nx = data_oe & (shaped ^ flip);
        unique case (tmode)
            TRG_DIV32: trig_nx = (div == '0);
            TRG_DIV8:  trig_nx = (div[2:0] == 3'd0);
            TRG_PATTERN, TRG_PATTERN_ALT: trig_nx = (pos == '0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div     <= '0;
            data_o  <= 1'b0;
            data_no <= 1'b1;
            trig_o  <= 1'b0;
        end else begin
            div     <= div + DIV_W'(1);
            data_o  <= bit_nx;
            data_no <= ~bit_nx;
            trig_o  <= trig_nx;
        end
    end

    assert_oe_static_R4: assert property (@(posedge clk) disable iff (rst)
        !data_oe |=> (!data_o && data_no));

    assert_zero_marker_R5: assert property (@(posedge clk) disable iff (rst)
        (zsub_en && is_short(sel_q) && pat_sel == sel_q && pos == '0 && data_oe && !flip)
        |=> data_o);

endmodule

// File: tb/test_prbs_tpg.sv
`timescale 1ns/1ps
module test_prbs_tpg;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  pat_sel;
    logic [1:0]  trig_mode;
    logic [2:0]  dens_code;
    logic        zsub_en;
    logic [12:0] zsub_len;
    logic        err_single, err_ext_n, rate_en, data_oe;
    logic [3:0]  rate_exp;
    logic        data_o, data_no, trig_o;

    always #4 clk = ~clk;

    prbs_tpg i_prbs_tpg (
        .clk(clk), .rst(rst), .pat_sel(pat_sel), .trig_mode(trig_mode),
        .dens_code(dens_code), .zsub_en(zsub_en), .zsub_len(zsub_len),
        .err_single(err_single), .err_ext_n(err_ext_n), .rate_en(rate_en),
        .rate_exp(rate_exp), .data_oe(data_oe),
        .data_o(data_o), .data_no(data_no), .trig_o(trig_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    bit    q_d[$];
    bit    q_t[$];
    string q_tag[$];

    // reference model state, built from the requirement text
    logic [30:0] m_s;
    logic [2:0]  m_sel;
    logic        m_b1, m_b2, m_sq, m_eq, m_on;
    logic [4:0]  m_div;
    longint      m_pos, m_cnt;

    function automatic int order_of(input logic [2:0] s);
        case (s)
            3'd0: return 7;   3'd1: return 10; 3'd2: return 11;
            3'd3: return 13;  3'd4: return 15; 3'd5: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic logic fb_of(input logic [2:0] s, input logic [30:0] r);
        case (s)
            3'd0: return r[6] ^ r[5];
            3'd1: return r[9] ^ r[6];
            3'd2: return r[10] ^ r[8];
            3'd3: return r[12] ^ r[11] ^ r[1] ^ r[0];
            3'd4: return r[14] ^ r[13];
            3'd5: return r[22] ^ r[17];
            default: return r[30] ^ r[27];
        endcase
    endfunction

    function automatic logic dens_of(input logic [2:0] code, input logic a, input logic b, input logic c);
        case (code)
            3'd1: return a & b & c;
            3'd2: return a & b;
            3'd3: return a & (b | c);
            3'd5: return a | (b & c);
            3'd6: return a | b;
            3'd7: return a | b | c;
            default: return a;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // driver: predicts the bit the next edge captures, pushes it, advances the model
    task automatic cyc(input string tag);
        int     w, ee;
        longint len, k, lim;
        logic   raw, fb, b, sev, eev, rh, flip, ed, et, shortp;
        w      = order_of(m_sel);
        len    = (longint'(1) << w) - 1;
        raw    = m_s[w-1];
        fb     = fb_of(m_sel, m_s);
        shortp = (m_sel <= 3'd3);
        b      = shortp ? dens_of(dens_code, raw, m_b1, m_b2) : raw;
        if (shortp && zsub_en) begin
            k = longint'(zsub_len);
            if (k > len - 1) k = len - 1;
            if (m_pos == 0)      b = 1'b1;
            else if (m_pos <= k) b = 1'b0;
        end
        ee  = (rate_exp < 3) ? 3 : ((rate_exp > 9) ? 9 : int'(rate_exp));
        lim = 1;
        for (int i = 0; i < ee; i++) lim = lim * 10;
        sev  = err_single && !m_sq;
        eev  = !err_ext_n && m_eq;
        rh   = m_on && rate_en && data_oe && (m_cnt >= lim - 1);
        flip = data_oe && (sev || eev || rh);
        ed   = data_oe ? (b ^ flip) : 1'b0;
        case (trig_mode)
            2'd1:    et = (m_div == 5'd0);
            2'd2:    et = (m_div[2:0] == 3'd0);
            default: et = (m_pos == 0);
        endcase
        q_d.push_back(ed);
        q_t.push_back(et);
        q_tag.push_back(tag);
        m_sq  = err_single;
        m_eq  = err_ext_n;
        m_div = m_div + 5'd1;
        if (pat_sel != m_sel) begin
            m_sel = pat_sel; m_s = '1; m_b1 = 0; m_b2 = 0; m_pos = 0;
        end else begin
            m_b2 = m_b1; m_b1 = raw;
            m_s  = {m_s[29:0], fb};
            m_pos = (m_pos == len - 1) ? 0 : m_pos + 1;
        end
        if (!m_on) begin
            m_cnt = 0;
            if (rate_en) m_on = 1;
        end else if (!rate_en) begin
            m_on = 0; m_cnt = 0;
        end else if (data_oe) begin
            m_cnt = rh ? 0 : m_cnt + 1;
        end
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    // monitor: pops the prediction for each edge and compares after it settles
    bit    mon_d, mon_t;
    string mon_tag;
    always @(posedge clk) begin
        #2;
        if (q_d.size() != 0) begin
            mon_d   = q_d.pop_front();
            mon_t   = q_t.pop_front();
            mon_tag = q_tag.pop_front();
            check(mon_tag, "data_o", data_o, mon_d);
            check(mon_tag, "trig_o", trig_o, mon_t);
            check("R4", "data_no", data_no, ~mon_d);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
            report();
        end
    end

    initial begin
        rst = 1'b1; pat_sel = 3'd0; trig_mode = 2'd0; dens_code = 3'd4;
        zsub_en = 1'b0; zsub_len = 13'd0; err_single = 1'b0; err_ext_n = 1'b1;
        rate_en = 1'b0; rate_exp = 4'd3; data_oe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "data_o", data_o, 1'b0);
        check("R1", "data_no", data_no, 1'b1);
        check("R1", "trig_o", trig_o, 1'b0);
        rst = 1'b0;
        m_s = '1; m_sel = pat_sel; m_b1 = 0; m_b2 = 0; m_sq = 0; m_eq = 1;
        m_on = 0; m_div = 5'd0; m_pos = 0; m_cnt = 0;

        run(300, "R2");                               // 7-bit sequence, two periods: R3 trigger
        run(10, "R3");
        pat_sel = 3'd6; run(200, "R12");
        pat_sel = 3'd3; run(100, "R12");
        pat_sel = 3'd1; run(100, "R2");
        pat_sel = 3'd2; run(100, "R2");
        pat_sel = 3'd4; run(100, "R2");
        pat_sel = 3'd5; run(100, "R2");
        pat_sel = 3'd7; run(60, "R2");
        trig_mode = 2'd1; run(100, "R11");
        trig_mode = 2'd2; run(50, "R11");
        trig_mode = 2'd3; pat_sel = 3'd0; run(140, "R3");
        trig_mode = 2'd0;

        pat_sel = 3'd1;
        for (int c = 0; c < 8; c++) begin
            dens_code = 3'(c);
            run(150, "R7");
        end
        dens_code = 3'd4;

        pat_sel = 3'd2; zsub_en = 1'b1; zsub_len = 13'd30; run(300, "R5");
        pat_sel = 3'd0; zsub_len = 13'h1fff; run(300, "R5");
        zsub_len = 13'd9; dens_code = 3'd1; run(260, "R5");

        pat_sel = 3'd4; run(200, "R6");
        pat_sel = 3'd6; dens_code = 3'd7; run(100, "R6");
        zsub_en = 1'b0; dens_code = 3'd4; pat_sel = 3'd0;
        run(5, "R2");

        for (int i = 0; i < 5; i++) begin
            err_single = 1'b1; run(3, "R8");
            err_single = 1'b0; run(6, "R8");
        end
        for (int i = 0; i < 5; i++) begin
            err_ext_n = 1'b0; run(3, "R9");
            err_ext_n = 1'b1; run(5, "R9");
        end

        rate_en = 1'b1; rate_exp = 4'd3; run(2600, "R10");
        rate_exp = 4'd0; run(1100, "R10");
        rate_en = 1'b0; run(20, "R10");

        data_oe = 1'b0; run(20, "R4");
        err_single = 1'b1; run(2, "R13");
        err_single = 1'b0; err_ext_n = 1'b0; run(2, "R13");
        err_ext_n = 1'b1; run(10, "R13");
        data_oe = 1'b1; run(10, "R13");
        rate_en = 1'b1; run(400, "R13");
        data_oe = 1'b0; run(500, "R13");
        data_oe = 1'b1; run(800, "R13");
        rate_en = 1'b0; run(5, "R13");

        @(posedge clk);
        #3;
        report();
    end

endmodule